// File: doc/BRIEF.md
# Programmable Asynchronous Serial Port

This block is a full-duplex asynchronous serial transmitter and receiver. Both directions run at the same time and on their own. A small byte-wide register bus sets the frame format and the bit rate at run time. The format covers 5 to 8 data bits, one or two stop bits, and no, even or odd parity. A 16-bit divisor is written as two byte registers. A bit lasts 16 × divisor system clocks. The transmitter and the receiver each have a one-character holding register in front of the shift register, so software has a whole character time to service each side.

The receiver samples the line sixteen times per bit. It accepts a start bit only if a majority vote near the middle of the bit still reads low. It then takes every later bit at the middle of its 16 sub-ticks. Five sticky status flags are kept: data ready, transmit holding empty, parity error, framing error and overrun. Each flag drives its own interrupt line through a mask bit. Register map (address → meaning): 0 data (a write fills the transmit holding register, a read returns received data), 1 divisor low byte, 2 divisor high byte, 3 format, 4 interrupt mask, 5 status.

Top module: `aserial_port`

## Requirements
- R1: After a synchronous reset, `ser_tx` is 1, `irq` is 0, and status (address 5) reads 0x22. Status bits are: bit0 data ready, bit1 transmit holding empty, bit2 parity error, bit3 framing error, bit4 overrun, bit5 transmitter idle.
- R2: A transmitted frame is one low start bit, then N data bits least significant first, then the optional parity bit, then the stop bits (high). The line idles high. N = 5 + format[1:0].
- R3: Format[4:3] selects the parity: 00 and 11 none, 01 even (the ones in data plus parity make an even count), 10 odd (they make an odd count).
- R4: Format[2] = 1 gives two stop bits, and 0 gives one. With the holding register refilled in time, consecutive start edges are exactly 16·D·L clocks apart, where L is the frame length in bits.
- R5: The divisor is D = {high byte, low byte}. Every transmitted bit lasts exactly 16·D system clocks.
- R6: With D = 0 the bit-rate generator stops. Nothing is transmitted, the line stays high, and a written character waits in the holding register.
- R7: A received character appears right-aligned and zero-extended at address 0 and sets data ready. Reading address 0 clears data ready. Transmit and receive can run at the same time.
- R8: A parity mismatch on a received character sets the parity error flag.
- R9: A stop bit sampled low sets the framing error flag.
- R10: A character that completes while data ready is still set raises overrun, and the older data stays in the register.
- R11: Reading status clears the parity error, framing error and overrun flags.
- R12: A write to address 0 while the transmit holding register is full is ignored. A second character is accepted once the first has moved into the shifter.
- R13: Each irq bit is the status flag with the same index ANDed with mask bit i, and it follows one clock after the flag or the mask changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data returned next cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ser_tx | output | 1 | Serial transmit line |
| ser_rx | input | 1 | Serial receive line (asynchronous) |
| irq | output | 5 | Masked interrupt per status flag |

## Verification
The embedded assertions check these on every cycle: the idle line stays high, the stopped generator emits no sub-ticks, a write to a full holding register leaves it unchanged, overrun rises only while data ready was set, data ready follows each received character, and no interrupt fires under a fully cleared mask. Only the bench scenarios can show the frame contents, parity polarity, stop-bit spacing, exact bit duration and right-aligned received data. The bench sweeps every length, parity and stop setting through a loopback and injects malformed frames from a bench-side driver.

// File: rtl/aser_pkg.sv
package aser_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_FLAGS = 5;
  localparam int FRAME_W   = 12;

  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_DLO  = 3'd1;
  localparam logic [2:0] A_DHI  = 3'd2;
  localparam logic [2:0] A_FMT  = 3'd3;
  localparam logic [2:0] A_MASK = 3'd4;
  localparam logic [2:0] A_STAT = 3'd5;

  typedef enum logic [1:0] {
    PAR_OFF  = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_OFF2 = 2'b11
  } parity_e;

  typedef struct packed {
    parity_e    par;
    logic       stop2;
    logic [1:0] len;
  } fmt_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_state_e;

  function automatic logic [3:0] char_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  function automatic logic par_on(input parity_e p);
    return (p == PAR_EVEN) || (p == PAR_ODD);
  endfunction
endpackage

// File: rtl/aser_tick_gen.sv
module aser_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (div == '0) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div - DIV_W'(1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DIV_W'(1);
      tick <= 1'b0;
    end
  end

  assert_no_tick_R6: assert property (@(posedge clk) disable iff (rst)
    (div == '0) |=> !tick);
endmodule

// File: rtl/aser_tx.sv
module aser_tx import aser_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  fmt_t              fmt,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              txd,
  output logic              thr_empty,
  output logic              tx_idle
);
  localparam int SUB_W = $clog2(OVS);

  logic [BYTE_W-1:0]  thr;
  logic               thr_full;
  logic               busy;
  logic [FRAME_W-1:0] shreg;
  logic [3:0]         left;
  logic [SUB_W-1:0]   sub;
  logic [FRAME_W-1:0] frame;
  logic [3:0]         flen;
  logic [3:0]         nbits;
  logic               pbit;
  logic               last_slot;
  logic               load;

  always_comb begin
    nbits = char_bits(fmt.len);
    frame = '1;
    frame[0] = 1'b0;
    pbit = (fmt.par == PAR_ODD);
    for (int i = 0; i < BYTE_W; i++) begin
      if (4'(i) < nbits) begin
        frame[i+1] = thr[i];
        pbit = pbit ^ thr[i];
      end
    end
    if (par_on(fmt.par)) frame[nbits + 4'd1] = pbit;
    flen = 4'd1 + nbits + {3'b000, par_on(fmt.par)} + (fmt.stop2 ? 4'd2 : 4'd1);
  end

  assign last_slot = busy && (sub == SUB_W'(OVS-1)) && (left == 4'd1);
  assign load      = tick && thr_full && (!busy || last_slot);

  always_ff @(posedge clk) begin
    if (rst) begin
      thr      <= '0;
      thr_full <= 1'b0;
      busy     <= 1'b0;
      shreg    <= '1;
      left     <= '0;
      sub      <= '0;
    end else begin
      if (wr_en && !thr_full) begin
        thr      <= wr_data;
        thr_full <= 1'b1;
      end
      if (load) begin
        shreg    <= frame;
        left     <= flen;
        sub      <= '0;
        busy     <= 1'b1;
        thr_full <= 1'b0;
      end else if (tick && busy) begin
        if (sub == SUB_W'(OVS-1)) begin
          sub   <= '0;
          shreg <= {1'b1, shreg[FRAME_W-1:1]};
          left  <= left - 4'd1;
          if (left == 4'd1) busy <= 1'b0;
        end else begin
          sub <= sub + SUB_W'(1);
        end
      end
    end
  end

  assign txd       = shreg[0];
  assign thr_empty = !thr_full;
  assign tx_idle   = !busy;

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  assert_frame_count_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (left != 4'd0));
  assert_full_write_dropped_R12: assert property (@(posedge clk) disable iff (rst)
    (wr_en && thr_full) |=> $stable(thr));
endmodule

// File: rtl/aser_rx.sv
module aser_rx import aser_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [1:0]        len,
  input  parity_e           par,
  input  logic              rxd,
  output logic              done,
  output logic [BYTE_W-1:0] data,
  output logic              perr,
  output logic              ferr
);
  localparam int SUB_W = $clog2(OVS);

  rx_state_e         state;
  logic              s1, s2;
  logic [1:0]        hist;
  logic              vote;
  logic [SUB_W-1:0]  sub;
  logic [3:0]        idx;
  logic [BYTE_W-1:0] sh;
  logic              acc;
  logic              pe_r;
  logic [3:0]        nbits;

  assign nbits = char_bits(len);
  assign vote  = (hist[1] & hist[0]) | (hist[1] & s2) | (hist[0] & s2);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= 1'b1;
      s2    <= 1'b1;
      hist  <= 2'b11;
      state <= RX_IDLE;
      sub   <= '0;
      idx   <= '0;
      sh    <= '0;
      acc   <= 1'b0;
      pe_r  <= 1'b0;
      done  <= 1'b0;
      data  <= '0;
      perr  <= 1'b0;
      ferr  <= 1'b0;
    end else begin
      s1   <= rxd;
      s2   <= s1;
      done <= 1'b0;
      if (tick) begin
        hist <= {hist[0], s2};
        case (state)
          RX_IDLE: begin
            if (hist[0] && !s2) begin
              state <= RX_START;
              sub   <= '0;
            end
          end
          RX_START: begin
            if (sub == SUB_W'(OVS/2-1)) begin
              sub <= '0;
              if (!vote) begin
                state <= RX_DATA;
                idx   <= '0;
                acc   <= (par == PAR_ODD);
                pe_r  <= 1'b0;
              end else begin
                state <= RX_IDLE;
              end
            end else begin
              sub <= sub + SUB_W'(1);
            end
          end
          RX_DATA: begin
            if (sub == SUB_W'(OVS-1)) begin
              sub <= '0;
              sh  <= {vote, sh[BYTE_W-1:1]};
              acc <= acc ^ vote;
              if (idx == nbits - 4'd1) state <= par_on(par) ? RX_PAR : RX_STOP;
              else                     idx   <= idx + 4'd1;
            end else begin
              sub <= sub + SUB_W'(1);
            end
          end
          RX_PAR: begin
            if (sub == SUB_W'(OVS-1)) begin
              sub   <= '0;
              pe_r  <= acc ^ vote;
              state <= RX_STOP;
            end else begin
              sub <= sub + SUB_W'(1);
            end
          end
          RX_STOP: begin
            if (sub == SUB_W'(OVS-1)) begin
              sub   <= '0;
              done  <= 1'b1;
              ferr  <= !vote;
              perr  <= pe_r;
              data  <= sh >> (4'd8 - nbits);
              state <= RX_IDLE;
            end else begin
              sub <= sub + SUB_W'(1);
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  assert_done_after_stop_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(state) == RX_STOP));
endmodule

// File: rtl/aserial_port.sv
module aserial_port import aser_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              ser_tx,
  input  logic              ser_rx,
  output logic [NUM_FLAGS-1:0] irq
);
  localparam int DIV_W = 2 * BYTE_W;

  logic [BYTE_W-1:0]    div_lo, div_hi;
  logic [4:0]           fmt_r;
  logic [NUM_FLAGS-1:0] mask;
  logic [BYTE_W-1:0]    rhr;
  logic                 dr, pe, fe, oe;
  fmt_t                 fmt;
  logic                 tick;
  logic                 tx_wr, rd_data, rd_stat;
  logic                 thr_empty, tx_idle;
  logic                 rx_done, rx_perr, rx_ferr;
  logic [BYTE_W-1:0]    rx_data;
  logic [NUM_FLAGS-1:0] flags;

  assign fmt     = fmt_t'(fmt_r);
  assign tx_wr   = bus_wr && (bus_addr == A_DATA);
  assign rd_data = bus_rd && (bus_addr == A_DATA);
  assign rd_stat = bus_rd && (bus_addr == A_STAT);
  assign flags   = {oe, fe, pe, thr_empty, dr};

  aser_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .div({div_hi, div_lo}), .tick(tick)
  );

  aser_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .fmt(fmt),
    .wr_en(tx_wr), .wr_data(bus_wdata),
    .txd(ser_tx), .thr_empty(thr_empty), .tx_idle(tx_idle)
  );

  aser_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .len(fmt.len), .par(fmt.par),
    .rxd(ser_rx), .done(rx_done), .data(rx_data),
    .perr(rx_perr), .ferr(rx_ferr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div_lo    <= '0;
      div_hi    <= '0;
      fmt_r     <= '0;
      mask      <= '0;
      rhr       <= '0;
      dr        <= 1'b0;
      pe        <= 1'b0;
      fe        <= 1'b0;
      oe        <= 1'b0;
      irq       <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_DLO:   div_lo <= bus_wdata;
          A_DHI:   div_hi <= bus_wdata;
          A_FMT:   fmt_r  <= bus_wdata[4:0];
          A_MASK:  mask   <= bus_wdata[NUM_FLAGS-1:0];
          default: ;
        endcase
      end

      if (rd_stat) begin
        pe <= 1'b0;
        fe <= 1'b0;
        oe <= 1'b0;
      end
      if (rx_done) begin
        dr <= 1'b1;
        if (dr && !rd_data) oe  <= 1'b1;
        else                rhr <= rx_data;
        if (rx_perr) pe <= 1'b1;
        if (rx_ferr) fe <= 1'b1;
      end else if (rd_data) begin
        dr <= 1'b0;
      end

      if (bus_rd) begin
        case (bus_addr)
          A_DATA:  bus_rdata <= rhr;
          A_DLO:   bus_rdata <= div_lo;
          A_DHI:   bus_rdata <= div_hi;
          A_FMT:   bus_rdata <= {3'b000, fmt_r};
          A_MASK:  bus_rdata <= {3'b000, mask};
          A_STAT:  bus_rdata <= {2'b00, tx_idle, flags};
          default: bus_rdata <= '0;
        endcase
      end

      irq <= flags & mask;
    end
  end

  assert_overrun_needs_ready_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> $past(dr));
  assert_ready_follows_rx_R7: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> dr);
  assert_masked_quiet_R13: assert property (@(posedge clk) disable iff (rst)
    (mask == '0 && $past(mask) == '0) |-> (irq == '0));
endmodule

// File: tb/aserial_port_test.sv
module aserial_port_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ser_tx, ser_rx;
  logic [4:0] irq;
  logic       use_loop = 1'b0;
  logic       drv_line = 1'b1;
  int         checks = 0, fails = 0;
  int         cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign ser_rx = use_loop ? ser_tx : drv_line;

  aserial_port uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_tx(ser_tx), .ser_rx(ser_rx), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic wait_bit(input int b, input logic val, input int tries);
    logic [7:0] s;
    for (int k = 0; k < tries; k++) begin
      rd(3'd5, s);
      if (s[b] == val) return;
    end
  endtask

  task automatic wait_low(input int limit);
    for (int k = 0; k < limit && ser_tx !== 1'b0; k++) @(negedge clk);
  endtask

  function automatic void mk_frame(input logic [7:0] d, input int n, input int par,
                                   input bit st2, output logic [11:0] f, output int L);
    logic p;
    int idx;
    f = '1; f[0] = 1'b0; p = (par == 2);
    for (int i = 0; i < n; i++) begin f[1+i] = d[i]; p = p ^ d[i]; end
    idx = 1 + n;
    if (par == 1 || par == 2) begin f[idx] = p; idx++; end
    L = idx + (st2 ? 2 : 1);
  endfunction

  task automatic send_raw(input logic [11:0] f, input int L);
    for (int i = 0; i < L; i++) begin
      drv_line = f[i];
      repeat (16) @(negedge clk);
    end
    drv_line = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0]  v, s;
    logic [11:0] f, got;
    int          L, t0, cnt;
    logic [7:0]  pats [4];
    pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'hFF; pats[3] = 8'h5A;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 line", ser_tx, 1);
    chk("R1 irq", irq, 0);
    chk("R1 rdata", bus_rdata, 0);
    rd(3'd5, s);
    chk("R1 status", s, 8'h22);

    wr(3'd1, 8'd1);

    // R2 R3 R7: loopback sweep of every format
    use_loop = 1'b1;
    for (int ln = 0; ln < 4; ln++)
      for (int pr = 0; pr < 4; pr++)
        for (int st = 0; st < 2; st++)
          for (int di = 0; di < 4; di++) begin
            wr(3'd3, {3'b000, pr[1:0], st[0], ln[1:0]});
            mk_frame(pats[di], ln + 5, pr, st[0], f, L);
            wr(3'd0, pats[di]);
            wait_low(100);
            got = '1;
            repeat (8) @(negedge clk);
            for (int b = 0; b < L; b++) begin
              got[b] = ser_tx;
              if (b < L - 1) repeat (16) @(negedge clk);
            end
            chk("R2 R3 frame", got & ((12'd1 << L) - 1), f & ((12'd1 << L) - 1));
            wait_bit(0, 1'b1, 40);
            rd(3'd5, s);
            chk("R7 ready no errors", s[4:0] & 5'h1D, 5'h01);
            rd(3'd0, v);
            chk("R7 data", v, pats[di] & ((8'd1 << (ln + 5)) - 1));
          end
    use_loop = 1'b0;

    // R4 R12: back-to-back frames
    for (int ln = 0; ln < 4; ln++)
      for (int pr = 0; pr < 4; pr++)
        for (int st = 0; st < 2; st++) begin
          wait_bit(5, 1'b1, 200);
          wr(3'd3, {3'b000, pr[1:0], st[0], ln[1:0]});
          mk_frame(8'h0F, ln + 5, pr, st[0], f, L);
          wr(3'd0, 8'h0F);
          wait_low(100);
          t0 = cyc;
          wr(3'd0, 8'hF0);
          while (cyc < t0 + 16 * L - 1) @(negedge clk);
          chk("R4 stop before next", ser_tx, 1);
          @(negedge clk);
          chk("R4 next start", ser_tx, 0);
        end
    wait_bit(5, 1'b1, 300);
    rd(3'd5, s);
    rd(3'd0, v);

    // R5: bit duration
    wr(3'd3, 8'h03);
    wr(3'd1, 8'd3);
    wr(3'd0, 8'h01);
    wait_low(200);
    cnt = 0;
    while (ser_tx === 1'b0 && cnt < 10000) begin cnt++; @(negedge clk); end
    chk("R5 start len div3", cnt, 48);
    wait_bit(5, 1'b1, 400);
    wr(3'd1, 8'd2);
    wr(3'd2, 8'd1);
    wr(3'd0, 8'h01);
    wait_low(2000);
    cnt = 0;
    while (ser_tx === 1'b0 && cnt < 10000) begin cnt++; @(negedge clk); end
    chk("R5 start len div258", cnt, 4128);
    wr(3'd2, 8'd0);
    wr(3'd1, 8'd1);
    wait_bit(5, 1'b1, 400);

    // R6 R12: stopped generator, dropped second write
    wr(3'd1, 8'd0);
    wr(3'd0, 8'h4D);
    wr(3'd0, 8'hB2);
    cnt = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (ser_tx !== 1'b1) cnt++;
    end
    chk("R6 line held high", cnt, 0);
    rd(3'd5, s);
    chk("R6 holding full", s[1], 0);
    chk("R6 idle", s[5], 1);
    use_loop = 1'b1;
    wr(3'd1, 8'd1);
    wait_bit(0, 1'b1, 200);
    rd(3'd0, v);
    chk("R12 first char kept", v, 8'h4D);
    repeat (400) @(negedge clk);
    rd(3'd5, s);
    chk("R12 second write dropped", s[0], 0);
    use_loop = 1'b0;

    // R8 R11: parity error
    wr(3'd3, 8'h0B);
    mk_frame(8'h01, 8, 1, 1'b0, f, L);
    f[9] = ~f[9];
    send_raw(f, L);
    rd(3'd5, s);
    chk("R8 parity flag", s[4:0] & 5'h1D, 5'h05);
    rd(3'd0, v);
    chk("R8 data", v, 8'h01);
    rd(3'd5, s);
    chk("R11 parity cleared", s[2], 0);

    // R9 R11: framing error
    wr(3'd3, 8'h03);
    mk_frame(8'h55, 8, 0, 1'b0, f, L);
    f[9] = 1'b0;
    send_raw(f, L);
    rd(3'd5, s);
    chk("R9 framing flag", s[3], 1);
    rd(3'd0, v);
    chk("R9 data", v, 8'h55);
    rd(3'd5, s);
    chk("R11 framing cleared", s[3], 0);

    // R10 R11: overrun
    mk_frame(8'h11, 8, 0, 1'b0, f, L);
    send_raw(f, L);
    mk_frame(8'h22, 8, 0, 1'b0, f, L);
    send_raw(f, L);
    rd(3'd5, s);
    chk("R10 overrun flag", s[4], 1);
    rd(3'd0, v);
    chk("R10 older data kept", v, 8'h11);
    rd(3'd5, s);
    chk("R11 overrun cleared", s[4], 0);

    // R13: interrupt masking
    wr(3'd4, 8'h01);
    @(negedge clk);
    chk("R13 nothing pending", irq, 0);
    mk_frame(8'h33, 8, 0, 1'b0, f, L);
    send_raw(f, L);
    chk("R13 ready irq", irq, 5'b00001);
    rd(3'd0, v);
    @(negedge clk);
    chk("R13 ready irq cleared", irq, 0);
    wr(3'd4, 8'h02);
    @(negedge clk);
    chk("R13 holding empty irq", irq, 5'b00010);
    wr(3'd4, 8'h00);
    @(negedge clk);
    chk("R13 all masked", irq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule